// File: doc/BRIEF.md
# PHY address discovery sequencer

This block finds the address of an Ethernet PHY attached to a management (MDIO) bus. It does not build MDIO frames itself. It drives a small command interface on an existing management master: a one-cycle read request with a PHY address and a register number, an idle flag from the master, and the read data the master returns. Each candidate address gets one read of the PHY basic status register (register 1), and the returned word is tested against a capability pattern.

A search starts with a start pulse. When a preset candidate is flagged as present, that address is tried first. If it passes, the search ends at once. If it fails or no preset was given, the sequencer walks the address space from the top address (31) down to 0 and takes the first address that passes. Every wait on the master's idle flag has a fixed poll budget. A stuck management port therefore ends with a failure of that address instead of a hang, and the walk carries on. At the end a one-cycle done pulse is raised. It comes with either a hit flag and the found address, or a miss flag. These results stay on the outputs until the next start.

Top module: `phy_locate_seq`

## Requirements
- R1: A start pulse is accepted only while the sequencer is not busy. A start pulse during a search changes neither the result nor the number of done pulses.
- R2: Every read request is a single-cycle pulse that names register 1. A request is issued only after the master has reported idle.
- R3: A status word passes only if it differs from 0xFFFF and has bits 12, 11 and 3 all set (mask 0x1808: 10M full duplex, 10M half duplex, auto-negotiation ability).
- R4: With a preset flagged as present, the preset address is read first. If it passes, it is reported as the hit after exactly one read.
- R5: If the preset fails or is absent, addresses are read in the order 31, 30, ... down to 0. The first one that passes is reported and no further address is read.
- R6: If no address passes, the miss flag is raised with the done pulse, after reads of all 32 addresses (33 reads when a preset was tried).
- R7: Each wait for the master to become idle, before and after a request, ends after 200 consecutive non-idle samples. That address then counts as failed and the walk continues with the next lower address.
- R8: Each accepted start produces exactly one single-cycle done pulse. With it, exactly one of hit or miss is high. The hit flag, miss flag and found address hold until the next accepted start.
- R9: Busy is high from the cycle after an accepted start and falls in the cycle in which done is high. After reset, busy, done, hit, miss and the request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a search (single-cycle pulse) |
| preset_vld_i | input | 1 | A preset candidate address is present |
| preset_addr_i | input | 5 | Preset candidate address |
| mgmt_idle_i | input | 1 | Management master is idle and its read data is valid |
| mgmt_rdata_i | input | 16 | Data from the last management read |
| mgmt_req_o | output | 1 | Read request pulse to the management master |
| mgmt_phy_o | output | 5 | PHY address of the request |
| mgmt_reg_o | output | 5 | Register number of the request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished (one cycle) |
| hit_o | output | 1 | A valid PHY address was found |
| miss_o | output | 1 | No valid PHY address was found |
| phy_addr_o | output | 5 | Found PHY address, valid while hit_o is high |

## Verification
A wrong walk address shows up on the request address port at the very next read, so the bench logs every request and compares the sequence with the expected preset-then-descending order. A corrupted validity decision or result register shows up in the cycle of the done pulse, as a wrong hit/miss flag or address. A broken poll timer shows up as extra or missing reads after a stuck address, or as a search that never finishes when the port stays busy. Extra done pulses or results that drift after done show up within a few cycles of the end of a search.

// File: rtl/phy_locate_pkg.sv
package phy_locate_pkg;

  typedef enum logic [2:0] {
    LS_IDLE  = 3'd0,
    LS_PRE   = 3'd1,
    LS_ISSUE = 3'd2,
    LS_POST  = 3'd3,
    LS_STEP  = 3'd4
  } loc_state_t;

endpackage

// File: rtl/mgmt_wait_timer.sv
module mgmt_wait_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic idle_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (!idle_i) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i & ~idle_i & (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/phy_status_judge.sv
module phy_status_judge #(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] CAP_MASK = 16'h1808
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              ok_o
);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CAP_MASK);

  logic all_ones;
  logic caps_ok;

  always_comb begin
    all_ones = (data_i == {DATA_W{1'b1}});
    caps_ok  = ((data_i & MASK_W) == MASK_W);
    ok_o     = caps_ok & ~all_ones;
  end

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              preset_vld_i,
  input  logic [ADDR_W-1:0] preset_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_preset_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pre_q, pre_d;
  logic              en;

  always_comb begin
    en     = load_i | adv_i;
    addr_d = addr_q;
    pre_d  = pre_q;
    if (load_i) begin
      addr_d = preset_vld_i ? preset_addr_i : TOP_ADDR;
      pre_d  = preset_vld_i;
    end else if (adv_i) begin
      if (pre_q) begin
        addr_d = TOP_ADDR;
        pre_d  = 1'b0;
      end else begin
        addr_d = addr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pre_q  <= 1'b0;
    end else if (en) begin
      addr_q <= addr_d;
      pre_q  <= pre_d;
    end
  end

  assign addr_o      = addr_q;
  assign in_preset_o = pre_q;
  assign last_o      = ~pre_q & (addr_q == '0);

endmodule

// File: rtl/phy_locate_seq.sv
module phy_locate_seq #(
  parameter int          ADDR_W     = 5,
  parameter int          REG_W      = 5,
  parameter int          DATA_W     = 16,
  parameter int          POLL_LIMIT = 200,
  parameter int          STAT_REG   = 1,
  parameter logic [15:0] CAP_MASK   = 16'h1808
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              preset_vld_i,
  input  logic [ADDR_W-1:0] preset_addr_i,
  input  logic              mgmt_idle_i,
  input  logic [DATA_W-1:0] mgmt_rdata_i,
  output logic              mgmt_req_o,
  output logic [ADDR_W-1:0] mgmt_phy_o,
  output logic [REG_W-1:0]  mgmt_reg_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [ADDR_W-1:0] phy_addr_o
);
  import phy_locate_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  loc_state_t        state_q, state_d;
  logic              pass_q, pass_d;
  logic              done_q, done_d;
  logic              hit_q, hit_d;
  logic              miss_q, miss_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              res_en;

  logic              load, adv;
  logic [ADDR_W-1:0] cur_addr;
  logic              in_preset;
  logic              last_addr;
  logic              tmr_run;
  logic              tmr_expire;
  logic              judge_ok;

  scan_addr_gen #(.ADDR_W(ADDR_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_i       (load),
    .preset_vld_i (preset_vld_i),
    .preset_addr_i(preset_addr_i),
    .adv_i        (adv),
    .addr_o       (cur_addr),
    .in_preset_o  (in_preset),
    .last_o       (last_addr)
  );

  assign tmr_run = (state_q == LS_PRE) || (state_q == LS_POST);

  mgmt_wait_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_i   (tmr_run),
    .idle_i  (mgmt_idle_i),
    .expire_o(tmr_expire)
  );

  phy_status_judge #(.DATA_W(DATA_W), .CAP_MASK(CAP_MASK)) u_judge (
    .data_i(mgmt_rdata_i),
    .ok_o  (judge_ok)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    done_d  = 1'b0;
    hit_d   = hit_q;
    miss_d  = miss_q;
    paddr_d = paddr_q;
    load    = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      LS_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          hit_d   = 1'b0;
          miss_d  = 1'b0;
          state_d = LS_PRE;
        end
      end
      LS_PRE: begin
        if (mgmt_idle_i) begin
          state_d = LS_ISSUE;
        end else if (tmr_expire) begin
          pass_d  = 1'b0;
          state_d = LS_STEP;
        end
      end
      LS_ISSUE: begin
        state_d = LS_POST;
      end
      LS_POST: begin
        if (mgmt_idle_i) begin
          pass_d  = judge_ok;
          state_d = LS_STEP;
        end else if (tmr_expire) begin
          pass_d  = 1'b0;
          state_d = LS_STEP;
        end
      end
      LS_STEP: begin
        if (pass_q) begin
          hit_d   = 1'b1;
          paddr_d = cur_addr;
          done_d  = 1'b1;
          state_d = LS_IDLE;
        end else if (last_addr) begin
          miss_d  = 1'b1;
          done_d  = 1'b1;
          state_d = LS_IDLE;
        end else begin
          adv     = 1'b1;
          state_d = LS_PRE;
        end
      end
      default: begin
        state_d = LS_IDLE;
      end
    endcase
  end

  assign res_en = ((state_q == LS_IDLE) && start_i) || (state_q == LS_STEP);

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= LS_IDLE;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      paddr_q <= '0;
    end else if (res_en) begin
      hit_q   <= hit_d;
      miss_q  <= miss_d;
      paddr_q <= paddr_d;
    end
  end

  assign mgmt_req_o = (state_q == LS_ISSUE);
  assign mgmt_phy_o = cur_addr;
  assign mgmt_reg_o = REG_W'(STAT_REG);
  assign busy_o     = (state_q != LS_IDLE);
  assign done_o     = done_q;
  assign hit_o      = hit_q;
  assign miss_o     = miss_q;
  assign phy_addr_o = paddr_q;

  // preset flag is consumed inside the walker; keep it visible for readers
  logic unused_ok;
  assign unused_ok = in_preset;

endmodule

// File: rtl/phy_locate_chk.sv
module phy_locate_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mgmt_idle_i,
  input logic              mgmt_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic [ADDR_W-1:0] phy_addr_o
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hit_o ^ miss_o));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req_o |=> !mgmt_req_o);

  // R2
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req_o |-> mgmt_idle_i);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(hit_o) && $stable(miss_o) && $stable(phy_addr_o)));

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

bind phy_locate_seq phy_locate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mgmt_idle_i(mgmt_idle_i),
  .mgmt_req_o (mgmt_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .hit_o      (hit_o),
  .miss_o     (miss_o),
  .phy_addr_o (phy_addr_o)
);

// File: tb/sim_phy_locate_seq.sv
`timescale 1ns/1ps
module sim_phy_locate_seq;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        preset_vld_i;
  logic [4:0]  preset_addr_i;
  logic        mgmt_idle_i;
  logic [15:0] mgmt_rdata_i;
  logic        mgmt_req_o;
  logic [4:0]  mgmt_phy_o;
  logic [4:0]  mgmt_reg_o;
  logic        busy_o;
  logic        done_o;
  logic        hit_o;
  logic        miss_o;
  logic [4:0]  phy_addr_o;

  phy_locate_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .preset_vld_i(preset_vld_i), .preset_addr_i(preset_addr_i),
    .mgmt_idle_i(mgmt_idle_i), .mgmt_rdata_i(mgmt_rdata_i),
    .mgmt_req_o(mgmt_req_o), .mgmt_phy_o(mgmt_phy_o), .mgmt_reg_o(mgmt_reg_o),
    .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o), .miss_o(miss_o),
    .phy_addr_o(phy_addr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // management master model
  logic [15:0] tbl [32];
  int          hang_addr = -1;
  int          hang_len  = 250;
  bit          hang_all  = 0;
  logic        m_idle;
  int          m_cnt;
  int          nreq;
  logic [4:0]  req_log [64];
  bit          bad_reg;

  assign mgmt_idle_i = hang_all ? 1'b0 : m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle       <= 1'b1;
      m_cnt        <= 0;
      mgmt_rdata_i <= 16'h0000;
    end else if (mgmt_req_o) begin
      m_idle       <= 1'b0;
      m_cnt        <= (int'(mgmt_phy_o) == hang_addr) ? hang_len : 3;
      mgmt_rdata_i <= tbl[mgmt_phy_o];
      if (nreq < 64) req_log[nreq] <= mgmt_phy_o;
      nreq         <= nreq + 1;
      if (mgmt_reg_o != 5'd1) bad_reg <= 1'b1;
    end else if (!m_idle) begin
      if (m_cnt <= 1) m_idle <= 1'b1;
      else m_cnt <= m_cnt - 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit good(input logic [15:0] v);
    return (v != 16'hFFFF) && ((v & 16'h1808) == 16'h1808);
  endfunction

  function automatic bit passes(input int a);
    return !hang_all && (a != hang_addr) && good(tbl[a]);
  endfunction

  logic [4:0] r_addr;
  bit         r_hit, r_miss, r_got;
  int         r_ndone;

  task automatic clear_tbl();
    for (int i = 0; i < 32; i++) tbl[i] = 16'hFFFF;
    hang_addr = -1;
    hang_all  = 0;
  endtask

  // runs one search and checks the full outcome against the rules
  task automatic run_case(input string name, input bit pv, input logic [4:0] pa,
                          input bit poke);
    bit   e_hit;
    int   e_addr, e_nreq, cyc, first;
    bit   busy_seen;
    logic [4:0] h_addr;
    bit         h_hit;
    e_hit = 0; e_addr = 0; e_nreq = 0; first = 0;
    if (!hang_all) begin
      if (pv) begin
        e_nreq = 1;
        if (passes(int'(pa))) begin e_hit = 1; e_addr = int'(pa); end
      end
      if (!e_hit) begin
        for (int a = 31; a >= 0; a--) begin
          if (!e_hit) begin
            e_nreq++;
            if (passes(a)) begin e_hit = 1; e_addr = a; end
          end
        end
      end
    end
    @(negedge clk);
    nreq = 0; bad_reg = 0;
    start_i = 1; preset_vld_i = pv; preset_addr_i = pa;
    @(negedge clk);
    start_i = 0;
    busy_seen = busy_o;
    r_got = 0; r_ndone = 0; cyc = 0;
    while (!r_got && cyc < 20000) begin
      if (done_o) begin
        r_got = 1; r_ndone = 1;
        r_hit = hit_o; r_miss = miss_o; r_addr = phy_addr_o;
        chk({name, " R9 busy low at done"}, int'(busy_o), 0);
      end else begin
        if (poke && cyc == 5) begin start_i = 1; preset_vld_i = 1; preset_addr_i = ~pa; end
        if (poke && cyc == 6) start_i = 0;
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 0;
    chk({name, " R9 busy after start"}, int'(busy_seen), 1);
    chk({name, " R8 search finished"}, int'(r_got), 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done_o) r_ndone++;
    end
    h_hit = hit_o; h_addr = phy_addr_o;
    chk({name, " R8 single done"}, r_ndone, 1);
    chk({name, " R8 hit/miss exclusive"}, int'(r_hit ^ r_miss), 1);
    chk({name, " R8 hit held"}, int'(h_hit), int'(r_hit));
    chk({name, " R5 hit flag"}, int'(r_hit), int'(e_hit));
    if (e_hit) chk({name, " R5 found address"}, int'(r_addr), e_addr);
    if (e_hit) chk({name, " R8 address held"}, int'(h_addr), e_addr);
    chk({name, " R6 miss flag"}, int'(r_miss), int'(!e_hit));
    chk({name, " R5 read count"}, nreq, e_nreq);
    chk({name, " R2 register number"}, int'(bad_reg), 0);
    for (int i = 0; i < nreq && i < 64; i++) begin
      first = pv ? ((i == 0) ? int'(pa) : 32 - i) : 31 - i;
      if (int'(req_log[i]) != first) begin
        chk({name, " R5 read order"}, int'(req_log[i]), first);
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset done", int'(done_o), 0);
    chk("R9 reset hit", int'(hit_o), 0);
    chk("R9 reset miss", int'(miss_o), 0);
    chk("R9 reset request", int'(mgmt_req_o), 0);
  endtask

  task automatic t_preset_good();
    clear_tbl();
    tbl[9] = 16'h7849; tbl[25] = 16'h1808;
    run_case("R4 preset passes", 1, 5'd9, 0);
    chk("R4 one read only", nreq, 1);
  endtask

  task automatic t_preset_allones();
    clear_tbl();
    tbl[7] = 16'h180D;
    run_case("R3 preset all ones", 1, 5'd14, 0);
    chk("R3 0xFFFF rejected, scan found 7", int'(r_addr), 7);
  endtask

  task automatic t_scan_first();
    clear_tbl();
    tbl[12] = 16'h1808; tbl[3] = 16'hFFF7;
    run_case("R5 highest wins", 0, 5'd0, 0);
  endtask

  task automatic t_partial_caps();
    clear_tbl();
    tbl[31] = 16'h0000; tbl[20] = 16'h1800; tbl[18] = 16'h0808;
    tbl[16] = 16'h1008; tbl[5] = 16'h180F;
    run_case("R3 missing bit rejected", 0, 5'd0, 0);
    chk("R3 address 5 chosen", int'(r_addr), 5);
  endtask

  task automatic t_bottom();
    clear_tbl();
    tbl[0] = 16'h1808;
    run_case("R5 address zero", 1, 5'd31, 0);
  endtask

  task automatic t_none();
    clear_tbl();
    tbl[4] = 16'h1800;
    run_case("R6 none valid no preset", 0, 5'd0, 0);
    chk("R6 32 reads", nreq, 32);
    run_case("R6 none valid with preset", 1, 5'd4, 0);
    chk("R6 33 reads", nreq, 33);
  endtask

  task automatic t_timeout_addr();
    clear_tbl();
    tbl[31] = 16'h1808; tbl[30] = 16'h1808;
    hang_addr = 31; hang_len = 250;
    run_case("R7 stuck address skipped", 0, 5'd0, 0);
    chk("R7 next lower taken", int'(r_addr), 30);
    hang_addr = -1;
  endtask

  task automatic t_hung_port();
    clear_tbl();
    tbl[10] = 16'h1808;
    hang_all = 1;
    run_case("R7 port stuck busy", 0, 5'd0, 0);
    chk("R7 no request while stuck", nreq, 0);
    hang_all = 0;
  endtask

  task automatic t_start_busy();
    clear_tbl();
    tbl[2] = 16'h1808; tbl[29 - 0] = 16'hFFFF;
    run_case("R1 start while busy", 0, 5'd0, 1);
    chk("R1 result unchanged", int'(r_addr), 2);
  endtask

  initial begin
    rst_n = 0; start_i = 0; preset_vld_i = 0; preset_addr_i = '0;
    nreq = 0; bad_reg = 0;
    for (int i = 0; i < 32; i++) tbl[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_preset_good();
    t_preset_allones();
    t_scan_first();
    t_partial_caps();
    t_bottom();
    t_none();
    t_timeout_addr();
    t_hung_port();
    t_start_busy();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule